// File: doc/BRIEF.md
# Bit-Packed Instruction Field Extractor

This block walks a store of densely packed, variable-length instructions. Instructions sit back to back with no byte or word alignment, so an instruction may be any number of bits long and the next one begins at the following bit. A bit pointer addresses the store, which is read through two word-wide read ports: the word holding the pointer and the word after it. Every cycle a shift window over those two words pulls out one field, whose width is set by fields already read. The order is fixed: a class code, a format field, zero to three operand references, and an opcode.

The class code indexes a small description table, given as a parameter. Each entry sets the operand count (order), the format width, the operand width and the opcode width. When the opcode is read, the block offers one record on a valid/ready handshake. The record holds the start bit address, the total length and every field value. The pointer then moves on to the next instruction. If any field would run past the last bit of the store, the block raises a sticky fault and stops. Executing instructions and giving meaning to opcodes are left to later stages.

Top module: `bitx_extractor`

## Requirements
- R1: After reset, outValid and fault are low and the first instruction is read from bit address 0 (memAddrLo is 0).
- R2: Stream bit k is bit (k mod 16) of store word k/16. Fields are read least significant bit first, so the first stream bit of a field is its bit 0.
- R3: Every instruction begins with a CLASS_W-bit class code. The code picks entry c of CLASS_TABLE at bits [13c +: 13]. Inside an entry, order is bits [1:0], format width is bits [4:2], opcode width is bits [7:5] and operand width is bits [12:8].
- R4: The format field follows the class code and is format-width bits long. It is absent when order is 0, and an absent or zero-width format is reported as 0.
- R5: Exactly `order` operand references follow, each operand-width bits long, and are reported in recOperands slot i at bits [16i +: 16]. Slots at or beyond order are reported as 0.
- R6: The opcode comes last and is opcode-width bits long. A class with opcode width 0 carries no opcode bits and reports 0.
- R7: recAddr is the bit address of the instruction's class code. recLen equals CLASS_W + format width + order × operand width + opcode width. The next instruction starts at recAddr + recLen.
- R8: While outValid is high and outReady is low, the record and outValid hold and no further bits are consumed.
- R9: A field that crosses a 16-bit word boundary is extracted correctly.
- R10: If reading a field would go past bit 65535, fault goes high and stays high, no further record is offered, and the partial instruction is dropped.
- R11: In the default table, class c has order c[1:0] and format width 0 for order 0, otherwise order+1. With g = c[3:2], operand width is 4(g+1) and opcode width is 0 when g is 3, otherwise g+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddrLo | output | 12 | Word address of the word holding the bit pointer |
| memAddrHi | output | 12 | Word address of the following word |
| memDataLo | input | 16 | Read data for memAddrLo, same cycle |
| memDataHi | input | 16 | Read data for memAddrHi, same cycle |
| outValid | output | 1 | Decoded record available |
| outReady | input | 1 | Consumer accepts the record |
| recAddr | output | 16 | Start bit address of the record's instruction |
| recLen | output | 9 | Total instruction length in bits |
| recClass | output | 4 | Class code |
| recFmt | output | 4 | Format field |
| recOperands | output | 48 | Three 16-bit operand reference slots |
| recOpcode | output | 5 | Opcode field |
| fault | output | 1 | Store end overrun, sticky until reset |

## Verification
The bench uses the default parameters: a 16-bit pointer, 16-bit words, a 4-bit class code and the computed default class table. These give operand widths of 4 to 16 bits, zero-width opcodes and formats, and fields that straddle word boundaries. With the full 65,536-bit store, filling the tail with shortest-class instructions drives the pointer to the end, so the overrun fault is reached in a run of tens of thousands of cycles. Consumer stalls early in the run exercise the record hold.

// File: rtl/bitx_pkg.sv
package bitx_pkg;

  localparam int ORDER_W = 2;
  localparam int MAX_OPS = (1 << ORDER_W) - 1;

  typedef enum logic [1:0] {SEL_CLASS, SEL_FMT, SEL_OP, SEL_OPC} fieldSel_t;

  typedef enum logic [2:0] {
    FS_CLASS, FS_FMT, FS_OP, FS_OPC, FS_EMIT, FS_HALT
  } fieldState_t;

  // entry layout, LSB first: order, format width, opcode width, operand width
  typedef struct packed {
    logic [4:0]         opLen;
    logic [2:0]         opcW;
    logic [2:0]         fmtW;
    logic [ORDER_W-1:0] order;
  } classInfo_t;

  localparam int ENTRY_W = $bits(classInfo_t);

  typedef struct packed {
    fieldSel_t          fieldSel;
    logic [ORDER_W-1:0] opIdx;
    logic               loadClass;
    logic               loadFmt;
    logic               loadOp;
    logic               loadOpc;
    logic               clearRec;
  } ctrlStrobe_t;

  function automatic logic [16*ENTRY_W-1:0] defaultClassTable();
    logic [16*ENTRY_W-1:0] tbl;
    classInfo_t e;
    tbl = '0;
    for (int c = 0; c < 16; c++) begin
      e.order = ORDER_W'(c & 3);
      e.fmtW  = (e.order == 0) ? 3'd0 : 3'(e.order + 1);
      e.opcW  = ((c >> 2) == 3) ? 3'd0 : 3'((c >> 2) + 3);
      e.opLen = 5'(4 * ((c >> 2) + 1));
      tbl[c*ENTRY_W +: ENTRY_W] = e;
    end
    return tbl;
  endfunction

endpackage

// File: rtl/bitx_window.sv
module bitx_window #(
  parameter int WORD_W = 16,
  parameter int SH_W   = 4,
  parameter int FW_W   = 5
) (
  input  logic [WORD_W-1:0] wordLo,
  input  logic [WORD_W-1:0] wordHi,
  input  logic [SH_W-1:0]   shift,
  input  logic [FW_W-1:0]   width,
  output logic [WORD_W-1:0] field
);
  logic [2*WORD_W-1:0] both;
  assign both = {wordHi, wordLo};

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      field[i] = (i < int'(width)) ? both[i + int'(shift)] : 1'b0;
    end
  end
endmodule

// File: rtl/bitx_datapath.sv
module bitx_datapath
  import bitx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 16,
  parameter int CLASS_W = 4,
  parameter int FMT_W   = 4,
  parameter int OPC_W   = 5,
  parameter int LEN_W   = 9,
  parameter logic [(1<<CLASS_W)*ENTRY_W-1:0] CLASS_TABLE = defaultClassTable(),
  localparam int SH_W   = $clog2(WORD_W),
  localparam int WA_W   = ADDR_W - SH_W,
  localparam int PTR_W  = ADDR_W + 1,
  localparam int FW_W   = $clog2(WORD_W + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  output classInfo_t               info,
  output logic                     fieldFits,
  output logic [WA_W-1:0]          memAddrLo,
  output logic [WA_W-1:0]          memAddrHi,
  input  logic [WORD_W-1:0]        memDataLo,
  input  logic [WORD_W-1:0]        memDataHi,
  output logic [ADDR_W-1:0]        recAddr,
  output logic [LEN_W-1:0]         recLen,
  output logic [CLASS_W-1:0]       recClass,
  output logic [FMT_W-1:0]         recFmt,
  output logic [MAX_OPS*WORD_W-1:0] recOperands,
  output logic [OPC_W-1:0]         recOpcode
);
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  instrStart;
  logic [FW_W-1:0]   fieldWidth;
  logic [WORD_W-1:0] field;
  logic              anyLoad;

  assign info = classInfo_t'(CLASS_TABLE[recClass*ENTRY_W +: ENTRY_W]);

  always_comb begin
    case (strobe.fieldSel)
      SEL_CLASS: fieldWidth = FW_W'(CLASS_W);
      SEL_FMT:   fieldWidth = FW_W'(info.fmtW);
      SEL_OP:    fieldWidth = FW_W'(info.opLen);
      default:   fieldWidth = FW_W'(info.opcW);
    endcase
  end

  assign fieldFits = ({1'b0, ptr} + (PTR_W+1)'(fieldWidth)) <= (PTR_W+1)'(1 << ADDR_W);
  assign memAddrLo = ptr[ADDR_W-1:SH_W];
  assign memAddrHi = memAddrLo + WA_W'(1);
  assign anyLoad   = strobe.loadClass | strobe.loadFmt | strobe.loadOp | strobe.loadOpc;

  bitx_window #(.WORD_W(WORD_W), .SH_W(SH_W), .FW_W(FW_W)) u_window (
    .wordLo(memDataLo), .wordHi(memDataHi), .shift(ptr[SH_W-1:0]),
    .width(fieldWidth), .field(field)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      instrStart <= '0;
      recClass   <= '0;
      recFmt     <= '0;
      recOpcode  <= '0;
    end else begin
      if (anyLoad)         ptr <= ptr + PTR_W'(fieldWidth);
      if (strobe.clearRec) begin
        instrStart <= ptr;
        recClass   <= '0;
        recFmt     <= '0;
        recOpcode  <= '0;
      end
      if (strobe.loadClass) recClass  <= field[CLASS_W-1:0];
      if (strobe.loadFmt)   recFmt    <= field[FMT_W-1:0];
      if (strobe.loadOpc)   recOpcode <= field[OPC_W-1:0];
    end
  end

  for (genvar g = 0; g < MAX_OPS; g++) begin : g_op
    logic [WORD_W-1:0] opReg;
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearRec) opReg <= '0;
      else if (strobe.loadOp && strobe.opIdx == ORDER_W'(g)) opReg <= field;
    end
    assign recOperands[g*WORD_W +: WORD_W] = opReg;
  end

  assign recAddr = instrStart[ADDR_W-1:0];
  assign recLen  = LEN_W'(ptr - instrStart);
endmodule

// File: rtl/bitx_control.sv
module bitx_control
  import bitx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  classInfo_t  info,
  input  logic        fieldFits,
  input  logic        outReady,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        fault
);
  fieldState_t        state, nextState;
  logic [ORDER_W-1:0] opCnt, nextOpCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextOpCnt = opCnt;
    outValid  = 1'b0;
    case (state)
      FS_CLASS: begin
        strobe.fieldSel = SEL_CLASS;
        if (fieldFits) begin
          strobe.loadClass = 1'b1;
          nextState = FS_FMT;
        end else nextState = FS_HALT;
      end
      FS_FMT: begin
        strobe.fieldSel = SEL_FMT;
        nextOpCnt = '0;
        if (fieldFits) begin
          strobe.loadFmt = 1'b1;
          nextState = (info.order != '0) ? FS_OP : FS_OPC;
        end else nextState = FS_HALT;
      end
      FS_OP: begin
        strobe.fieldSel = SEL_OP;
        strobe.opIdx = opCnt;
        if (fieldFits) begin
          strobe.loadOp = 1'b1;
          if (opCnt + ORDER_W'(1) == info.order) nextState = FS_OPC;
          else nextOpCnt = opCnt + ORDER_W'(1);
        end else nextState = FS_HALT;
      end
      FS_OPC: begin
        strobe.fieldSel = SEL_OPC;
        if (fieldFits) begin
          strobe.loadOpc = 1'b1;
          nextState = FS_EMIT;
        end else nextState = FS_HALT;
      end
      FS_EMIT: begin
        outValid = 1'b1;
        if (outReady) begin
          strobe.clearRec = 1'b1;
          nextState = FS_CLASS;
        end
      end
      default: nextState = FS_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= FS_CLASS;
      opCnt <= '0;
    end else begin
      state <= nextState;
      opCnt <= nextOpCnt;
    end
  end

  assign fault = (state == FS_HALT);
endmodule

// File: rtl/bitx_extractor.sv
module bitx_extractor
  import bitx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 16,
  parameter int CLASS_W = 4,
  parameter int FMT_W   = 4,
  parameter int OPC_W   = 5,
  parameter int LEN_W   = 9,
  parameter logic [(1<<CLASS_W)*ENTRY_W-1:0] CLASS_TABLE = defaultClassTable(),
  localparam int WA_W   = ADDR_W - $clog2(WORD_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  output logic [WA_W-1:0]           memAddrLo,
  output logic [WA_W-1:0]           memAddrHi,
  input  logic [WORD_W-1:0]         memDataLo,
  input  logic [WORD_W-1:0]         memDataHi,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [ADDR_W-1:0]         recAddr,
  output logic [LEN_W-1:0]          recLen,
  output logic [CLASS_W-1:0]        recClass,
  output logic [FMT_W-1:0]          recFmt,
  output logic [MAX_OPS*WORD_W-1:0] recOperands,
  output logic [OPC_W-1:0]          recOpcode,
  output logic                      fault
);
  ctrlStrobe_t strobe;
  classInfo_t  info;
  logic        fieldFits;

  bitx_control u_ctrl (
    .clk(clk), .rstN(rstN), .info(info), .fieldFits(fieldFits),
    .outReady(outReady), .strobe(strobe), .outValid(outValid), .fault(fault)
  );

  bitx_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CLASS_W(CLASS_W), .FMT_W(FMT_W),
    .OPC_W(OPC_W), .LEN_W(LEN_W), .CLASS_TABLE(CLASS_TABLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .info(info), .fieldFits(fieldFits),
    .memAddrLo(memAddrLo), .memAddrHi(memAddrHi),
    .memDataLo(memDataLo), .memDataHi(memDataHi),
    .recAddr(recAddr), .recLen(recLen), .recClass(recClass), .recFmt(recFmt),
    .recOperands(recOperands), .recOpcode(recOpcode)
  );
endmodule

// File: rtl/bitx_checker.sv
module bitx_checker
  import bitx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 16,
  parameter int CLASS_W = 4,
  parameter int FMT_W   = 4,
  parameter int OPC_W   = 5,
  parameter int LEN_W   = 9,
  parameter logic [(1<<CLASS_W)*ENTRY_W-1:0] CLASS_TABLE = defaultClassTable()
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      outValid,
  input logic                      outReady,
  input logic [ADDR_W-1:0]         recAddr,
  input logic [LEN_W-1:0]          recLen,
  input logic [CLASS_W-1:0]        recClass,
  input logic [FMT_W-1:0]          recFmt,
  input logic [MAX_OPS*WORD_W-1:0] recOperands,
  input logic [OPC_W-1:0]          recOpcode,
  input logic                      fault
);
  logic [ADDR_W:0] lastEnd;
  logic            haveLast;
  classInfo_t      curInfo;

  assign curInfo = classInfo_t'(CLASS_TABLE[recClass*ENTRY_W +: ENTRY_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastEnd  <= '0;
      haveLast <= 1'b0;
    end else if (outValid && outReady) begin
      lastEnd  <= {1'b0, recAddr} + (ADDR_W+1)'(recLen);
      haveLast <= 1'b1;
    end
  end

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);
  assert_no_record_on_fault_R10: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !outValid);
  assert_record_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(recAddr) && $stable(recLen)
      && $stable(recClass) && $stable(recFmt) && $stable(recOperands) && $stable(recOpcode)));
  assert_contiguous_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveLast) |-> ({1'b0, recAddr} == lastEnd));
  assert_min_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (recLen >= LEN_W'(CLASS_W)));
  assert_no_format_order0_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && curInfo.order == '0) |-> (recFmt == '0));
  assert_no_opcode_width0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && curInfo.opcW == '0) |-> (recOpcode == '0));
endmodule

bind bitx_extractor bitx_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CLASS_W(CLASS_W), .FMT_W(FMT_W),
  .OPC_W(OPC_W), .LEN_W(LEN_W), .CLASS_TABLE(CLASS_TABLE)
) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .recAddr(recAddr), .recLen(recLen), .recClass(recClass), .recFmt(recFmt),
  .recOperands(recOperands), .recOpcode(recOpcode), .fault(fault)
);

// File: tb/sim_bitx_extractor.sv
module sim_bitx_extractor;
  typedef struct {
    int             addr;
    int             len;
    logic [3:0]     cls;
    logic [3:0]     fmt;
    logic [15:0]    ops [3];
    logic [4:0]     opc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] memAddrLo, memAddrHi;
  logic [15:0] memDataLo, memDataHi;
  logic        outValid, outReady, fault;
  logic [15:0] recAddr;
  logic [8:0]  recLen;
  logic [3:0]  recClass, recFmt;
  logic [47:0] recOperands;
  logic [4:0]  recOpcode;

  logic [15:0] mem [0:4095];
  exp_t        expQ[$];
  int          cursor = 0;
  int          checks = 0;
  int          fails  = 0;

  always #2 clk = ~clk;

  assign memDataLo = mem[memAddrLo];
  assign memDataHi = mem[memAddrHi];

  bitx_extractor u0 (
    .clk(clk), .rstN(rstN), .memAddrLo(memAddrLo), .memAddrHi(memAddrHi),
    .memDataLo(memDataLo), .memDataHi(memDataHi), .outValid(outValid),
    .outReady(outReady), .recAddr(recAddr), .recLen(recLen), .recClass(recClass),
    .recFmt(recFmt), .recOperands(recOperands), .recOpcode(recOpcode), .fault(fault)
  );

  // default class table rule (R11)
  function automatic int tOrder(int c); return c & 3; endfunction
  function automatic int tFmtW(int c); return (tOrder(c) == 0) ? 0 : tOrder(c) + 1; endfunction
  function automatic int tOpcW(int c); return ((c >> 2) == 3) ? 0 : (c >> 2) + 3; endfunction
  function automatic int tOpLen(int c); return 4 * ((c >> 2) + 1); endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2: LSB-first packing
  task automatic writeBits(input logic [15:0] v, input int w);
    for (int i = 0; i < w; i++) begin
      mem[cursor >> 4][cursor % 16] = v[i];
      cursor++;
    end
  endtask

  task automatic putInstr(input int c, input logic [15:0] f, input logic [15:0] a0,
                          input logic [15:0] a1, input logic [15:0] a2, input logic [15:0] oc);
    exp_t e;
    logic [15:0] src [3];
    src[0] = a0; src[1] = a1; src[2] = a2;
    e.addr = cursor;
    e.cls  = 4'(c);
    e.fmt  = 4'(f & 16'((1 << tFmtW(c)) - 1));
    e.opc  = 5'(oc & 16'((1 << tOpcW(c)) - 1));
    writeBits(16'(c), 4);
    writeBits(16'(e.fmt), tFmtW(c));
    for (int i = 0; i < 3; i++) begin
      if (i < tOrder(c)) begin
        e.ops[i] = (tOpLen(c) == 16) ? src[i] : (src[i] & 16'((1 << tOpLen(c)) - 1));
        writeBits(e.ops[i], tOpLen(c));
      end else e.ops[i] = '0;
    end
    writeBits(16'(e.opc), tOpcW(c));
    e.len = cursor - e.addr;
    expQ.push_back(e);
  endtask

  // consumer: stalls early on, then always ready
  initial begin
    int k;
    k = 0;
    outReady = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      k++;
      outReady = (k > 4000) || ($urandom % 4 != 0);
    end
  end

  // monitor / scoreboard
  logic        prevStall = 1'b0;
  logic [86:0] heldRec;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(outValid && ({recAddr, recLen, recClass, recFmt, recOperands, recOpcode} == heldRec),
              "R8", "record hold", int'(outValid), 1);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R7", "unexpected record addr", int'(recAddr), -1);
        else begin
          exp_t e;
          bit ok;
          e = expQ.pop_front();
          ok = (int'(recAddr) == e.addr) && (int'(recLen) == e.len) && (recClass == e.cls)
             && (recFmt == e.fmt) && (recOpcode == e.opc)
             && (recOperands[15:0] == e.ops[0]) && (recOperands[31:16] == e.ops[1])
             && (recOperands[47:32] == e.ops[2]);
          // R3 R4 R5 R6 R7 R9: all fields of the record at once
          check(ok, "R3/R4/R5/R6/R7/R9", $sformatf("record @%0d cls %0h fmt %0h opc %0h ops %0h len",
                e.addr, recClass, recFmt, recOpcode, recOperands), int'(recLen), e.len);
          if (!ok)
            $display("      expected cls %0h fmt %0h opc %0h ops %0h/%0h/%0h addr %0d",
                     e.cls, e.fmt, e.opc, e.ops[0], e.ops[1], e.ops[2], e.addr);
        end
      end
      prevStall = outValid && !outReady;
      heldRec   = {recAddr, recLen, recClass, recFmt, recOperands, recOpcode};
    end
  end

  initial begin
    bit done;
    rstN = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // directed: each class, word-crossing 16-bit operands, zero-width opcode
    putInstr(0, 0, 0, 0, 0, 5);
    putInstr(3, 16'hA, 16'h3, 16'h9, 16'hF, 6);
    putInstr(15, 16'h5, 16'hBEEF, 16'h1234, 16'hCAFE, 0);
    putInstr(12, 0, 0, 0, 0, 0);
    putInstr(9, 16'h2, 16'hABC, 0, 0, 16'h1F);
    putInstr(6, 16'h7, 16'hA5, 16'h5A, 0, 16'hD);
    putInstr(13, 16'h3, 16'h8001, 0, 0, 0);
    for (int n = 0; n < 16; n++) putInstr(n, 16'hF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h1F);
    for (int n = 0; n < 60; n++)
      putInstr(int'($urandom % 16), 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom));
    // tail: class 0 (7 bits, all zero) until the store end; then R10 overrun
    while (cursor + 7 <= 65536) begin
      exp_t e;
      e.addr = cursor; e.len = 7; e.cls = 0; e.fmt = 0; e.opc = 0;
      for (int i = 0; i < 3; i++) e.ops[i] = '0;
      expQ.push_back(e);
      cursor += 7;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid, "R1", "outValid in reset", int'(outValid), 0);
    check(!fault, "R1", "fault in reset", int'(fault), 0);
    check(memAddrLo == 0, "R1", "start word", int'(memAddrLo), 0);
    @(posedge clk);
    #1 rstN = 1'b1;

    done = 1'b0;
    for (int c = 0; c < 150000 && !done; c++) begin
      @(posedge clk);
      done = fault && (expQ.size() == 0);
    end
    if (!done) check(1'b0, "R10", "watchdog, records left", expQ.size(), 0);

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(fault, "R10", "fault sticky at store end", int'(fault), 1);
    check(!outValid, "R10", "no record after fault", int'(outValid), 0);
    check(expQ.size() == 0, "R10", "records outstanding", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule